// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block gathers interrupt conditions from several neighbouring units into one 32-bit status word that a host reads and acknowledges through a simple register port. Three bits latch one-cycle events and hold them until the host writes 1 to them. These are a software interrupt, a device-ready announcement and a general purpose timer underflow. Five more bits are live copies of pending summaries kept by other units. These come from a timestamping unit, the switch fabric, two PHY ports and the GPIO unit. Such a bit clears only when its source drops its summary, and host writes do not touch it.

A companion 32-bit enable word uses the same bit positions. The single request line `irq_out` is high whenever any status bit is set together with its enable bit. The software interrupt is raised by the host itself, at the moment it turns bit 31 of the enable word from 0 to 1.

A two-state machine tracks the device-ready input. In state BOOT it waits for `dev_ready`. The transition BOOT to LIVE happens on the first cycle `dev_ready` is high, and it emits one ready event. The transition LIVE to BOOT happens whenever `dev_ready` goes low, which re-arms the announcement. The timer input is the live 16-bit count. An underflow is recognised when one cycle shows 0x0000 and the next shows 0xFFFF.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the latched status bits and the enable word are 0, `irq_out` is 0, and the status word read with all source inputs low is 0.
- R2: The status word is read at address 0x058 and the enable word at 0x05C. Any other address reads 0. In the status word, bits 25:20, 18:13 and 11:0 always read 0.
- R3: Status bit 29 follows `ts_pend`, bit 28 follows `fab_pend`, bit 27 follows `phy2_pend`, bit 26 follows `phy1_pend` and bit 12 follows `gpio_pend`, all in the same cycle. Host writes to these bits have no effect.
- R4: Status bit 19 is set at the clock edge following a cycle in which `tmr_count` is 0xFFFF and the cycle before it showed 0x0000. No other pair of consecutive counts sets it.
- R5: Status bit 30 is set once each time the ready machine moves from BOOT to LIVE. While `dev_ready` stays high, a cleared bit 30 stays cleared.
- R6: Status bit 31 is set by a write to the enable word that changes enable bit 31 from 0 to 1. Writing 1 to enable bit 31 when it is already 1 does not set it.
- R7: Writing 1 to bit 31, 30 or 19 of the status word clears that bit at the write edge. Writing 0 to it leaves it unchanged.
- R8: If an event for a latched bit occurs in the same cycle as a write of 1 to that bit, the bit remains set.
- R9: Status bits show their conditions regardless of the enable word.
- R10: `irq_out` is the OR over bit positions of status AND enable, and follows in the same cycle.
- R11: Enable bits 31, 30, 29, 28, 27, 26, 19 and 12 are read/write. All other enable bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register address, selects the word for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| tmr_count | input | 16 | Live count of the general purpose timer |
| dev_ready | input | 1 | Device-ready level |
| ts_pend | input | 1 | Timestamping unit pending summary |
| fab_pend | input | 1 | Switch fabric pending summary |
| phy2_pend | input | 1 | PHY port 2 pending summary |
| phy1_pend | input | 1 | PHY port 1 pending summary |
| gpio_pend | input | 1 | GPIO pending summary |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A latched bit that is set or cleared wrongly appears in the status read one cycle after the event or write edge. A wrong ready state shows up as a missing or repeated bit 30 on the next cycle that `dev_ready` changes. An enable bit stored wrongly is visible at once, both when the enable word is read back and on `irq_out` as soon as any source at that position is active. A bad timer history register would set bit 19 on the wrong count pair, and the sweep over count pairs catches this one cycle after the pair.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_W    = 32;
    localparam int BIT_SW   = 31;
    localparam int BIT_RDY  = 30;
    localparam int BIT_TS   = 29;
    localparam int BIT_FAB  = 28;
    localparam int BIT_PHY2 = 27;
    localparam int BIT_PHY1 = 26;
    localparam int BIT_TMR  = 19;
    localparam int BIT_GPIO = 12;
    localparam int N_LATCH  = 3;

    localparam logic [REG_W-1:0] LATCH_MASK =
        (32'h1 << BIT_SW) | (32'h1 << BIT_RDY) | (32'h1 << BIT_TMR);
    localparam logic [REG_W-1:0] MIRROR_MASK =
        (32'h1 << BIT_TS) | (32'h1 << BIT_FAB) | (32'h1 << BIT_PHY2) |
        (32'h1 << BIT_PHY1) | (32'h1 << BIT_GPIO);
    localparam logic [REG_W-1:0] IMPL_MASK = LATCH_MASK | MIRROR_MASK;

    typedef enum logic [0:0] {RDY_BOOT, RDY_LIVE} rdy_state_t;

    // index of latched source -> status bit position
    function automatic int latch_pos(input int idx);
        case (idx)
            0:       return BIT_SW;
            1:       return BIT_RDY;
            default: return BIT_TMR;
        endcase
    endfunction
endpackage

// File: rtl/irq_rdy_fsm.sv
module irq_rdy_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_ready,
    output logic rdy_evt
);
    rdy_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RDY_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rdy_evt = 1'b0;
        unique case (state_q)
            RDY_BOOT: begin
                if (dev_ready) begin
                    state_d = RDY_LIVE;
                    rdy_evt = 1'b1;
                end
            end
            RDY_LIVE: begin
                if (!dev_ready) state_d = RDY_BOOT;
            end
        endcase
    end
endmodule

// File: rtl/irq_wrap_det.sv
module irq_wrap_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);
    logic [CNT_W-1:0] prev_q;

    // history starts at all ones so a count of all ones right after reset is not an underflow
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= cnt;
    end

    assign wrap_evt = (prev_q == '0) && (&cnt);
endmodule

// File: rtl/irq_w1c_bit.sv
module irq_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (set_evt) q <= 1'b1;
        else if (clr)     q <= 1'b0;
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h058,
    parameter logic [ADDR_W-1:0] EN_OFS  = 'h05C,
    parameter int                TMR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [TMR_W-1:0]  tmr_count,
    input  logic              dev_ready,
    input  logic              ts_pend,
    input  logic              fab_pend,
    input  logic              phy2_pend,
    input  logic              phy1_pend,
    input  logic              gpio_pend,
    output logic              irq_out
);
    logic             sts_wr, en_wr;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] sts_word;
    logic             sw_evt, rdy_evt, wrap_evt;
    logic [N_LATCH-1:0] latch_evt, latch_q;

    assign sts_wr = reg_wr && (reg_addr == STS_OFS);
    assign en_wr  = reg_wr && (reg_addr == EN_OFS);

    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= reg_wdata & IMPL_MASK;
    end

    // software interrupt: enable bit for position 31 goes from 0 to 1
    assign sw_evt = en_wr && reg_wdata[BIT_SW] && !en_q[BIT_SW];

    irq_rdy_fsm u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_ready (dev_ready),
        .rdy_evt   (rdy_evt)
    );

    irq_wrap_det #(.CNT_W(TMR_W)) u_wrap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (tmr_count),
        .wrap_evt (wrap_evt)
    );

    assign latch_evt = {wrap_evt, rdy_evt, sw_evt};

    for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
        irq_w1c_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (latch_evt[i]),
            .clr     (sts_wr && reg_wdata[latch_pos(i)]),
            .q       (latch_q[i])
        );
    end

    always_comb begin
        sts_word = '0;
        for (int i = 0; i < N_LATCH; i++) sts_word[latch_pos(i)] = latch_q[i];
        sts_word[BIT_TS]   = ts_pend;
        sts_word[BIT_FAB]  = fab_pend;
        sts_word[BIT_PHY2] = phy2_pend;
        sts_word[BIT_PHY1] = phy1_pend;
        sts_word[BIT_GPIO] = gpio_pend;
    end

    always_comb begin
        if (reg_addr == STS_OFS)     reg_rdata = sts_word;
        else if (reg_addr == EN_OFS) reg_rdata = en_q;
        else                         reg_rdata = '0;
    end

    assign irq_out = |(sts_word & en_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] STS_OFS = 'h058
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              wd_tmr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_out,
    input logic [REG_W-1:0]  sts_word,
    input logic [REG_W-1:0]  en_q,
    input logic              wrap_evt,
    input logic              rdy_evt,
    input logic              sw_evt
);
    logic clr_tmr;
    assign clr_tmr = reg_wr && (reg_addr == STS_OFS) && wd_tmr;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STS_OFS) |-> ((reg_rdata & ~IMPL_MASK) == '0)); // R2
    AST_TMR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> sts_word[BIT_TMR]); // R4
    AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_evt |=> sts_word[BIT_RDY]); // R5
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> sts_word[BIT_SW]); // R6
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tmr && !wrap_evt) |=> !sts_word[BIT_TMR]); // R7
    AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_word[BIT_TMR] && !clr_tmr) |=> sts_word[BIT_TMR]); // R7
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tmr && wrap_evt) |=> sts_word[BIT_TMR]); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out); // R10
    AST_EN_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~IMPL_MASK) == '0)); // R11
endmodule

bind irq_status_agg irq_agg_chk #(.ADDR_W(ADDR_W), .STS_OFS(STS_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wd_tmr    (reg_wdata[19]),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .sts_word  (sts_word),
    .en_q      (en_q),
    .wrap_evt  (wrap_evt),
    .rdy_evt   (rdy_evt),
    .sw_evt    (sw_evt)
);

// File: tb/test_irq_status_agg.sv
module test_irq_status_agg;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_STS = 12'h058;
    localparam logic [11:0] A_EN  = 12'h05C;
    localparam logic [31:0] IMPL  = 32'hFC08_1000;
    localparam int MPOS [5] = '{29, 28, 27, 26, 12};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] tmr_count = 16'h1234;
    logic        dev_ready = 1'b0;
    logic        ts_pend = 1'b0, fab_pend = 1'b0, phy2_pend = 1'b0;
    logic        phy1_pend = 1'b0, gpio_pend = 1'b0;
    logic        irq_out;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg i_irq_status_agg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_count(tmr_count),
        .dev_ready(dev_ready), .ts_pend(ts_pend), .fab_pend(fab_pend),
        .phy2_pend(phy2_pend), .phy1_pend(phy1_pend), .gpio_pend(gpio_pend),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic set_mirrors(input logic [4:0] m);
        {ts_pend, fab_pend, phy2_pend, phy1_pend, gpio_pend} = m;
    endtask

    function automatic logic [31:0] mword(input logic [4:0] m);
        logic [31:0] w = '0;
        for (int k = 0; k < 5; k++) if (m[4-k]) w |= (32'h1 << MPOS[k]);
        return w;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] v;
        logic [15:0] pa [5] = '{16'h0000, 16'h0001, 16'h0000, 16'hFFFF, 16'h0000};
        logic [15:0] pb [5] = '{16'hFFFF, 16'hFFFF, 16'hFFFE, 16'h0000, 16'h0000};
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(A_STS, v); chk("R1 status after reset", v, 32'h0);
        rd(A_EN, v);  chk("R1 enable after reset", v, 32'h0);
        chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        // R2 unmapped address reads zero
        rd(12'h054, v); chk("R2 unmapped address", v, 32'h0);
        // R11 sweep each enable bit
        for (int b = 0; b < 31; b++) begin
            wr(A_EN, 32'h1 << b);
            rd(A_EN, v); chk($sformatf("R11 enable bit %0d", b), v, (32'h1 << b) & IMPL);
        end
        // R6 set enable bit 31 from 0 -> software bit latches
        wr(A_EN, 32'h8000_0000);
        rd(A_STS, v); chk("R6 sw bit set by enable rise", v, 32'h8000_0000);
        chk("R10 irq from sw bit", {31'h0, irq_out}, 32'h1);
        wr(A_STS, 32'h0000_0000);
        rd(A_STS, v); chk("R7 write 0 keeps sw bit", v, 32'h8000_0000);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, v); chk("R7 write 1 clears sw bit", v, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_STS, v); chk("R6 enable already set no new sw bit", v, 32'h0);
        rd(A_EN, v);  chk("R11 enable all ones masked", v, IMPL);
        wr(A_EN, 32'h0);
        // R3/R9 mirror sweep with enables off
        for (int m = 0; m < 32; m++) begin
            @(negedge clk); set_mirrors(5'(m));
            rd(A_STS, v); chk($sformatf("R3 mirror pattern %0d", m), v, mword(5'(m)));
            chk($sformatf("R9 no irq while disabled %0d", m), {31'h0, irq_out}, 32'h0);
        end
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, v); chk("R3 write ignored by mirrors", v, mword(5'h1F));
        // R10 mirror x enable matrix
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
                wr(A_EN, 32'h1 << MPOS[j]);
                @(negedge clk); set_mirrors(5'(1 << (4 - i)));
                #1; chk($sformatf("R10 src %0d en %0d", i, j), {31'h0, irq_out}, {31'h0, i == j});
            end
        @(negedge clk); set_mirrors(5'h0);
        wr(A_EN, 32'h0);
        // R4 timer count pair sweep
        for (int c = 0; c < 5; c++) begin
            @(negedge clk); tmr_count = 16'h0005;
            @(negedge clk); tmr_count = pa[c];
            @(negedge clk); tmr_count = pb[c];
            tick(1);
            rd(A_STS, v); chk($sformatf("R4 pair %h->%h", pa[c], pb[c]), v,
                (pa[c] == 16'h0 && pb[c] == 16'hFFFF) ? 32'h0008_0000 : 32'h0);
            wr(A_STS, 32'h0008_0000);
            rd(A_STS, v); chk("R7 timer bit cleared", v, 32'h0);
        end
        // R8 event and clear in the same cycle
        @(negedge clk); tmr_count = 16'h0000;
        @(negedge clk); tmr_count = 16'hFFFF;
        reg_addr = A_STS; reg_wdata = 32'h0008_0000; reg_wr = 1'b1;
        tick(1); reg_wr = 1'b0;
        rd(A_STS, v); chk("R8 event beats clear", v, 32'h0008_0000);
        wr(A_STS, 32'h0008_0000);
        rd(A_STS, v); chk("R8 later clear works", v, 32'h0);
        // R5 ready announcement
        @(negedge clk); dev_ready = 1'b1;
        tick(1);
        rd(A_STS, v); chk("R5 ready bit set", v, 32'h4000_0000);
        wr(A_STS, 32'h4000_0000);
        tick(4);
        rd(A_STS, v); chk("R5 ready held no re-set", v, 32'h0);
        @(negedge clk); dev_ready = 1'b0;
        @(negedge clk); dev_ready = 1'b1;
        tick(1);
        rd(A_STS, v); chk("R5 ready re-armed after drop", v, 32'h4000_0000);
        wr(A_EN, 32'h4000_0000);
        #1; chk("R10 irq from ready bit", {31'h0, irq_out}, 32'h1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule